// File: doc/BRIEF.md
# Dynamic bus-sizing bus sequencer

This block runs one external bus cycle at a time for a processor-side request on a shared 32-bit address/data bus. A request carries a byte address, a datum size (byte, halfword or word), a read/write flag and a four-word burst flag. The requester also gives the width of the memory port that the access lands on, as 8, 16 or 32 bits. The block presents an address phase with a one-cycle latch strobe. It then runs one data beat per port-width slice of the datum. During this it steps a 4-bit low-address output, so a wide datum is split across a narrow port and a four-word read counts through the whole 16-byte block.

The address phase carries address bits 31:4 and four byte-lane enables on bits 3:0. For writes, each data beat carries the slice of the write word that belongs to the current low address, and an acknowledge moves to the next beat. For reads, the bus is released and data-enable is raised. Each read-data-valid strobe captures one beat into an assembled word. The acknowledge then closes the cycle, and a single done pulse returns the word. A write that directly follows another write into the same 256-byte page is marked on the burst/write-near output. On a read, that same output marks a four-word request.

Top module: `bus_sizing_seq`

## Requirements
- R1: One cycle after a request is accepted, the address phase lasts exactly one cycle. In it `ale`=1 and `ad_oe`=1, and `ad_out[31:4]` equals request address bits 31:4. In every other cycle `ale`=0.
- R2: In the address phase, `ad_out[3:0]` holds byte-lane enables, active high, where bit n enables data lane [8n+7:8n]. A byte enables lane addr[1:0]. A halfword enables lanes {addr[1],0} and {addr[1],1}. A word or a four-word read enables all four. Size codes are 0=byte, 1=halfword, 2=word.
- R3: When `cfg_rd_strb_off`=1 at acceptance, the lane enables of a read are 0000. Writes are not affected.
- R4: For writes and single reads, the low address starts at request address bits 3:0. It is shown in the address phase and in the first data cycle. It advances by the port width in bytes after each beat, and the number of beats is max(1, datum bytes / port bytes). Port codes are 0=8-bit, 1=16-bit, 2=32-bit.
- R5: A four-word read (`req_quad`=1 with `req_write`=0) starts the low address at 0000 and runs 16 / port-bytes beats. A four-word flag on a write is ignored, and the write runs as a single write.
- R6: `data_en`=1 exactly in the data phase of a read, and there `ad_oe`=0. It is 0 for writes, for the address phase and when idle.
- R7: In each write data beat `ad_out` = write data shifted right by 8×k. Here k is 0 for a 32-bit port, {low_addr[1],0} for a 16-bit port and low_addr[1:0] for an 8-bit port. `ack`=1 ends a beat, and on the last beat it ends the cycle.
- R8: On a read, `rdce`=1 captures a beat when low_addr[3:2] equals request address bits 3:2. A 32-bit port stores all of `ad_in`. A 16-bit port stores `ad_in[15:0]` at half low_addr[1]. An 8-bit port stores `ad_in[7:0]` at byte low_addr[1:0]. Bytes that are not captured read 0. `ack` closes the cycle only after all beats are captured.
- R9: `burst_near`=1 for the whole cycle of a four-word read. On a write it is 1 when the previous bus cycle was a write with equal address bits 31:8 and was followed directly by this request.
- R10: An idle cycle (ready with no request) or any read clears the write-near history.
- R11: `rd_o`/`wr_o` are asserted from the address phase until the final acknowledge and are never both 1. `done` pulses for exactly one cycle right after the final acknowledge. `req_ready`=1 only when idle. After reset the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present (accepted when req_ready) |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_quad | input | 1 | Four-word block read |
| req_wdata | input | 32 | Write word, lane-aligned |
| port_width | input | 2 | 0 8-bit, 1 16-bit, 2 32-bit |
| cfg_rd_strb_off | input | 1 | Suppress lane enables on reads |
| req_ready | output | 1 | Idle, can accept |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word, valid with done |
| ale | output | 1 | Address latch strobe |
| ad_oe | output | 1 | Block drives the shared bus |
| ad_out | output | 32 | Shared bus output value |
| ad_in | input | 32 | Shared bus input value |
| data_en | output | 1 | Memory may drive the bus |
| low_addr | output | 4 | Current datum low address |
| rd_o | output | 1 | Read cycle in progress |
| wr_o | output | 1 | Write cycle in progress |
| burst_near | output | 1 | Four-word read / same-page write |
| ack | input | 1 | Memory acknowledge |
| rdce | input | 1 | Read data valid strobe |

## Verification
The assertions take for granted that requests are naturally aligned. They also assume the port width describes the addressed memory and that `ack` and `rdce` arrive only in the data phase, with at most one `rdce` per beat. The stimulus keeps to this. It raises each strobe for one cycle per beat, sometimes after a wait cycle, and on reads it gives the closing acknowledge with or after the last data strobe. Aligned addresses are chosen for every size and port pairing.

// File: rtl/bsz_pkg.sv
// Shared encodings for the bus-sizing sequencer.
// Assumes: size and port codes 3 are treated as word / 32-bit.
package bsz_pkg;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ADDR = 2'd1, ST_DATA = 2'd2} bsz_state_e;

    // Clamp a size or width code to the range 0..2.
    function automatic logic [1:0] clamp_code(input logic [1:0] c);
        return (c == 2'd3) ? 2'd2 : c;
    endfunction
endpackage

// File: rtl/bsz_plan.sv
// Works out, from a request, the lane enables, first low address,
// low-address step and beat count.
// Assumes: naturally aligned requests; purely combinational.
module bsz_plan
    import bsz_pkg::*;
#(
    parameter int LA_W = 4
) (
    input  logic [LA_W-1:0] addr_lo,
    input  logic [1:0]      size,
    input  logic [1:0]      port,
    input  logic            write,
    input  logic            quad,
    input  logic            rd_strb_off,
    output logic [3:0]      strb,
    output logic [LA_W-1:0] la_start,
    output logic [LA_W-1:0] la_step,
    output logic [LA_W-1:0] beats_m1,
    output logic            is_quad
);
    logic [1:0]    sz, pw, base, bytes_m1;
    logic [3:0]    mask, raw;
    logic [LA_W:0] nbeats, nb_m1;

    // Beat count and step from size, port width and burst kind.
    always_comb begin
        sz      = clamp_code(size);
        pw      = clamp_code(port);
        is_quad = quad && !write;
        if (is_quad)
            nbeats = (LA_W+1)'(1 << LA_W) >> pw;
        else if (sz > pw)
            nbeats = (LA_W+1)'(1) << (sz - pw);
        else
            nbeats = (LA_W+1)'(1);
        nb_m1    = nbeats - (LA_W+1)'(1);
        beats_m1 = nb_m1[LA_W-1:0];
        la_step  = LA_W'(1) << pw;
        la_start = is_quad ? '0 : addr_lo;
    end

    // Lane enables from size and low address bits.
    always_comb begin
        case (sz)
            2'd0:    begin mask = 4'b0001; bytes_m1 = 2'b00; end
            2'd1:    begin mask = 4'b0011; bytes_m1 = 2'b01; end
            default: begin mask = 4'b1111; bytes_m1 = 2'b11; end
        endcase
        base = addr_lo[1:0] & ~bytes_m1;
        raw  = is_quad ? 4'b1111 : (mask << base);
        strb = (!write && rd_strb_off) ? 4'b0000 : raw;
    end
endmodule

// File: rtl/bsz_lowaddr.sv
// Low-address counter: loads the first datum address and steps by the
// port width in bytes per beat, wrapping within the 16-byte block.
// Assumes: load and advance are never both set.
module bsz_lowaddr #(
    parameter int LA_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [LA_W-1:0] start,
    input  logic            advance,
    input  logic [LA_W-1:0] step,
    output logic [LA_W-1:0] la
);
    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)       la <= '0;
        else if (load)    la <= start;
        else if (advance) la <= la + step;
    end

    AST_LA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!load && !advance) |=> $stable(la)); // R4
endmodule

// File: rtl/bsz_near.sv
// Same-page write tracker: remembers the page of the last write and
// reports a hit for a write that follows it directly.
// Assumes: accept is a single-cycle pulse per request.
module bsz_near #(
    parameter int PAGE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              write,
    input  logic              idle_gap,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    logic              near_vld;
    logic [PAGE_W-1:0] near_page;

    // History update: set on writes, cleared by reads and idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            near_vld  <= 1'b0;
            near_page <= '0;
        end else if (accept && write) begin
            near_vld  <= 1'b1;
            near_page <= page;
        end else if ((accept && !write) || idle_gap) begin
            near_vld  <= 1'b0;
        end
    end

    assign hit = near_vld && (near_page == page);

    AST_NEAR_CLR: assert property (@(posedge clk) disable iff (!rst_n) idle_gap |=> !near_vld); // R10
endmodule

// File: rtl/bsz_gather.sv
// Read word assembly: places each captured beat into its lanes of the
// word addressed by the request.
// Assumes: port code already clamped to 0..2.
module bsz_gather #(
    parameter int DATA_W = 32,
    parameter int LA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [LA_W-1:0]   la,
    input  logic [1:0]        pw,
    input  logic [1:0]        tgt_word,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] word
);
    localparam int LANES = DATA_W / 8;

    logic take;
    assign take = cap && (la[3:2] == tgt_word);

    // One register slice per byte lane.
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic       sel;
        logic [7:0] src;
        always_comb begin
            case (pw)
                2'd0:    begin sel = (la[1:0] == 2'(b)); src = din[7:0]; end
                2'd1:    begin sel = (la[1] == b[1]);    src = din[8*(b%2) +: 8]; end
                default: begin sel = 1'b1;               src = din[8*b +: 8]; end
            endcase
        end
        // Lane capture.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)      word[8*b +: 8] <= 8'h00;
            else if (take && sel)   word[8*b +: 8] <= src;
        end
    end
endmodule

// File: rtl/bus_sizing_seq.sv
// Bus-sizing sequencer top: accepts one request, runs the address phase
// and the data beats a narrow port needs, then pulses done.
// Assumes: ack/rdce only in the data phase; one rdce per read beat.
module bus_sizing_seq
    import bsz_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int PAGE_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_quad,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        port_width,
    input  logic              cfg_rd_strb_off,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              ale,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              data_en,
    output logic [3:0]        low_addr,
    output logic              rd_o,
    output logic              wr_o,
    output logic              burst_near,
    input  logic              ack,
    input  logic              rdce
);
    localparam int LA_W   = 4;
    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    bsz_state_e        state;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic              q_wr, q_near, q_off, got_all, done_r;
    logic [1:0]        q_pw;
    logic [3:0]        q_strb;
    logic [LA_W-1:0]   q_step, q_beats_m1, beat_cnt;

    logic [3:0]        p_strb;
    logic [LA_W-1:0]   p_start, p_step, p_beats_m1;
    logic              p_quad, near_hit;
    logic              accept, idle_gap, in_data, last_beat, cap, beat_adv, finish;
    logic [1:0]        w_off;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign idle_gap = (state == ST_IDLE) && !req_valid;
    assign in_data  = (state == ST_DATA);

    bsz_plan #(.LA_W(LA_W)) u_plan (
        .addr_lo(req_addr[LA_W-1:0]), .size(req_size), .port(port_width),
        .write(req_write), .quad(req_quad), .rd_strb_off(cfg_rd_strb_off),
        .strb(p_strb), .la_start(p_start), .la_step(p_step),
        .beats_m1(p_beats_m1), .is_quad(p_quad)
    );

    bsz_near #(.PAGE_W(PAGE_W)) u_near (
        .clk(clk), .rst_n(rst_n), .accept(accept), .write(req_write),
        .idle_gap(idle_gap), .page(req_addr[ADDR_W-1:PAGE_LSB]), .hit(near_hit)
    );

    bsz_lowaddr #(.LA_W(LA_W)) u_la (
        .clk(clk), .rst_n(rst_n), .load(accept), .start(p_start),
        .advance(beat_adv), .step(q_step), .la(low_addr)
    );

    bsz_gather #(.DATA_W(DATA_W), .LA_W(LA_W)) u_gather (
        .clk(clk), .rst_n(rst_n), .clr(accept), .cap(cap), .la(low_addr),
        .pw(q_pw), .tgt_word(q_addr[3:2]), .din(ad_in), .word(rdata)
    );

    // Beat bookkeeping for the data phase.
    always_comb begin
        last_beat = (beat_cnt == q_beats_m1);
        cap       = in_data && !q_wr && rdce && !got_all;
        if (q_wr) begin
            beat_adv = in_data && ack && !last_beat;
            finish   = in_data && ack && last_beat;
        end else begin
            beat_adv = cap && !last_beat;
            finish   = in_data && ack && (got_all || (cap && last_beat));
        end
    end

    // Phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else case (state)
            ST_IDLE: if (accept) state <= ST_ADDR;
            ST_ADDR: state <= ST_DATA;
            ST_DATA: if (finish) state <= ST_IDLE;
            default: state <= ST_IDLE;
        endcase
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr <= '0; q_wdata <= '0; q_wr <= 1'b0; q_pw <= 2'd2;
            q_strb <= '0; q_near <= 1'b0; q_off <= 1'b0;
            q_step <= '0; q_beats_m1 <= '0;
        end else if (accept) begin
            q_addr     <= req_addr;
            q_wdata    <= req_wdata;
            q_wr       <= req_write;
            q_pw       <= clamp_code(port_width);
            q_strb     <= p_strb;
            q_near     <= p_quad || (req_write && near_hit);
            q_off      <= cfg_rd_strb_off;
            q_step     <= p_step;
            q_beats_m1 <= p_beats_m1;
        end
    end

    // Beat counter, read completion flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt <= '0; got_all <= 1'b0; done_r <= 1'b0;
        end else begin
            done_r <= finish;
            if (accept) begin
                beat_cnt <= '0;
                got_all  <= 1'b0;
            end else begin
                if (beat_adv) beat_cnt <= beat_cnt + LA_W'(1);
                if (cap && last_beat) got_all <= 1'b1;
            end
        end
    end

    // Lane offset of the current write slice.
    always_comb begin
        case (q_pw)
            2'd0:    w_off = low_addr[1:0];
            2'd1:    w_off = {low_addr[1], 1'b0};
            default: w_off = 2'd0;
        endcase
    end

    assign req_ready  = (state == ST_IDLE);
    assign done       = done_r;
    assign ale        = (state == ST_ADDR);
    assign ad_oe      = ale || (in_data && q_wr);
    assign ad_out     = ale ? {q_addr[ADDR_W-1:4], q_strb} : (q_wdata >> {w_off, 3'b000});
    assign data_en    = in_data && !q_wr;
    assign rd_o       = (state != ST_IDLE) && !q_wr;
    assign wr_o       = (state != ST_IDLE) && q_wr;
    assign burst_near = (state != ST_IDLE) && q_near;

    AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R1
    AST_DEN_READ: assert property (@(posedge clk) disable iff (!rst_n) data_en |-> (rd_o && !ad_oe)); // R6
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_o && wr_o)); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (req_ready && !rd_o && !wr_o)); // R11
    AST_STRB_OFF: assert property (@(posedge clk) disable iff (!rst_n) (ale && rd_o && q_off) |-> (ad_out[3:0] == 4'b0000)); // R3
    AST_LA_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ale |=> $stable(low_addr)); // R4
    AST_QUAD_START: assert property (@(posedge clk) disable iff (!rst_n) (ale && rd_o && burst_near) |-> (low_addr == 4'h0)); // R5
endmodule

// File: tb/bus_sizing_seq_tb.sv
`timescale 1ns/1ps
module bus_sizing_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, req_valid, req_write, req_quad, cfg_off, ack, rdce;
    logic [31:0] req_addr, req_wdata, ad_in;
    logic [1:0]  req_size, port_width;
    logic        req_ready, done, ale, ad_oe, data_en, rd_o, wr_o, burst_near;
    logic [31:0] rdata, ad_out;
    logic [3:0]  low_addr;

    int checks = 0, errors = 0;
    bit ended = 0;
    logic [7:0]  mem [16];
    bit          near_ok = 0;
    logic [23:0] near_pg = '0;

    always #2.5 clk = ~clk;

    bus_sizing_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_quad(req_quad),
        .req_wdata(req_wdata), .port_width(port_width), .cfg_rd_strb_off(cfg_off),
        .req_ready(req_ready), .done(done), .rdata(rdata), .ale(ale), .ad_oe(ad_oe),
        .ad_out(ad_out), .ad_in(ad_in), .data_en(data_en), .low_addr(low_addr),
        .rd_o(rd_o), .wr_o(wr_o), .burst_near(burst_near), .ack(ack), .rdce(rdce)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] port_data(input logic [1:0] pw, input logic [3:0] la);
        logic [3:0] h, w;
        h = la & 4'hE;
        w = la & 4'hC;
        case (pw)
            2'd0:    return {24'h0, mem[la]};
            2'd1:    return {16'h0, mem[h | 4'd1], mem[h]};
            default: return {mem[w | 4'd3], mem[w | 4'd2], mem[w | 4'd1], mem[w]};
        endcase
    endfunction

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            chk("R11 done single pulse", {31'b0, done}, 32'd0);
            chk("R1 ale low when idle", {31'b0, ale}, 32'd0);
            chk("R6 data_en low when idle", {31'b0, data_en}, 32'd0);
        end
        if (n > 0) near_ok = 0;
    endtask

    // One bus cycle, checked every clock against a behavioural expectation.
    task automatic txn(input logic [31:0] a, input logic [1:0] sz, input bit wr, input bit qd,
                       input logic [31:0] wd, input logic [1:0] pw, input bit late);
        bit          eq;
        int          pb, bytes, nb, base, off;
        logic [3:0]  es, start, la;
        logic [31:0] exp_rd;
        bit          exp_near;
        int          lo, cnt;
        eq    = qd && !wr;
        pb    = 1 << pw;
        bytes = 1 << sz;
        nb    = eq ? 16 / pb : ((bytes > pb) ? bytes / pb : 1);
        start = eq ? 4'h0 : a[3:0];
        base  = int'(a[1:0]) & ~(bytes - 1);
        es    = 4'b0000;
        for (int b = 0; b < 4; b++)
            if (eq || (b >= base && b < base + bytes)) es[b] = 1'b1;
        if (!wr && cfg_off) es = 4'b0000;
        exp_near = eq ? 1'b1 : (wr && near_ok && (near_pg == a[31:8]));

        chk("R11 ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1; req_addr = a; req_size = sz; req_write = wr;
        req_quad = qd; req_wdata = wd; port_width = pw;
        @(posedge clk); #1;
        req_valid = 0;
        chk("R1 ale in address phase", {31'b0, ale}, 32'd1);
        chk("R1 ad_oe in address phase", {31'b0, ad_oe}, 32'd1);
        chk("R1 R2 R3 address phase bus", ad_out, {a[31:4], es});
        chk("R4 R5 first low address", {28'b0, low_addr}, {28'b0, start});
        chk("R11 rd/wr in address phase", {30'b0, rd_o, wr_o}, {30'b0, !wr, wr});
        chk("R9 burst_near", {31'b0, burst_near}, {31'b0, exp_near});
        chk("R6 data_en low in address phase", {31'b0, data_en}, 32'd0);
        chk("R11 ready low when busy", {31'b0, req_ready}, 32'd0);

        la = start;
        for (int i = 0; i < nb; i++) begin
            la = 4'(int'(start) + i * pb);
            for (int wcyc = 0; wcyc < ((i % 2 == 0) ? 2 : 1); wcyc++) begin
                @(posedge clk); #1;
                ack = 0; rdce = 0; ad_in = '0;
                chk("R1 ale low in data phase", {31'b0, ale}, 32'd0);
                chk("R4 R5 low address per beat", {28'b0, low_addr}, {28'b0, la});
                chk("R6 data_en in data phase", {31'b0, data_en}, {31'b0, !wr});
                chk("R6 R7 ad_oe in data phase", {31'b0, ad_oe}, {31'b0, wr});
                chk("R9 burst_near held", {31'b0, burst_near}, {31'b0, exp_near});
                if (wr) begin
                    off = (pw == 2'd2) ? 0 : (pw == 2'd1) ? (la[1] ? 2 : 0) : int'(la[1:0]);
                    chk("R7 write slice", ad_out, wd >> (8 * off));
                end
            end
            if (wr) ack = 1;
            else begin
                rdce  = 1;
                ad_in = port_data(pw, la);
                ack   = (i == nb - 1) && !late;
            end
        end
        @(posedge clk); #1;
        ack = 0; rdce = 0; ad_in = '0;
        if (!wr && late) begin
            chk("R8 waits for ack", {31'b0, done}, 32'd0);
            chk("R4 low address holds after last beat", {28'b0, low_addr}, {28'b0, la});
            chk("R6 data_en until ack", {31'b0, data_en}, 32'd1);
            ack = 1;
            @(posedge clk); #1;
            ack = 0;
        end
        chk("R11 done pulse", {31'b0, done}, 32'd1);
        chk("R11 rd/wr released", {30'b0, rd_o, wr_o}, 32'd0);
        chk("R6 data_en released", {31'b0, data_en}, 32'd0);
        chk("R11 ready after cycle", {31'b0, req_ready}, 32'd1);
        if (!wr) begin
            exp_rd = '0;
            lo  = (eq || pw == 2'd2) ? 0 : (int'(a[1:0]) & ~(pb - 1));
            cnt = (eq || pw == 2'd2) ? 4 : nb * pb;
            for (int b = 0; b < 4; b++)
                if (b >= lo && b < lo + cnt) exp_rd[8*b +: 8] = mem[{a[3:2], 2'(b)}];
            chk("R8 assembled read word", rdata, exp_rd);
        end
        if (wr) begin near_ok = 1; near_pg = a[31:8]; end
        else near_ok = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 37 + 5);
        rst_n = 0; req_valid = 0; req_addr = '0; req_size = 2'd0; req_write = 0;
        req_quad = 0; req_wdata = '0; port_width = 2'd2; cfg_off = 0;
        ack = 0; rdce = 0; ad_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("R11 reset ready", {31'b0, req_ready}, 32'd1);
        chk("R11 reset rd/wr", {30'b0, rd_o, wr_o}, 32'd0);
        chk("R11 reset done", {31'b0, done}, 32'd0);
        chk("R1 reset ale", {31'b0, ale}, 32'd0);
        chk("R6 reset data_en", {31'b0, data_en}, 32'd0);
        idle(1);

        txn(32'h1234_5674, 2'd2, 1, 0, 32'hDEAD_BEEF, 2'd2, 0);  // word write, 32-bit port
        txn(32'h1234_5612, 2'd1, 1, 0, 32'hA5C3_0000, 2'd1, 0);  // R9 same page, half/16
        txn(32'h1234_6603, 2'd0, 1, 0, 32'h7700_0000, 2'd0, 0);  // other page, byte/8
        txn(32'h1234_6604, 2'd2, 1, 0, 32'h4433_2211, 2'd0, 0);  // R9 word split on 8-bit
        idle(2);
        txn(32'h1234_6608, 2'd2, 1, 0, 32'h0BAD_F00D, 2'd1, 0);  // R10 idle cleared history
        txn(32'h1234_6618, 2'd2, 0, 0, 32'h0, 2'd0, 0);          // word read on 8-bit port
        txn(32'h1234_6620, 2'd2, 1, 0, 32'h1357_9BDF, 2'd2, 0);  // R10 read cleared history
        txn(32'h0000_1234, 2'd2, 0, 1, 32'h0, 2'd1, 1);          // R5 quad read 16-bit, late ack
        txn(32'h0000_1238, 2'd2, 0, 1, 32'h0, 2'd2, 0);          // R5 quad read 32-bit
        txn(32'h0000_2006, 2'd1, 0, 0, 32'h0, 2'd2, 0);          // R2 half read lanes 1100
        cfg_off = 1;
        txn(32'h0000_2006, 2'd1, 0, 0, 32'h0, 2'd2, 0);          // R3 strobes suppressed
        txn(32'h0000_2005, 2'd0, 1, 0, 32'h0000_9900, 2'd2, 0);  // R3 write not affected
        cfg_off = 0;
        idle(1);
        txn(32'h0000_3003, 2'd0, 0, 0, 32'h0, 2'd0, 1);          // byte read on 8-bit port
        txn(32'h0000_3001, 2'd0, 0, 0, 32'h0, 2'd1, 0);          // byte read on 16-bit port
        txn(32'h0000_3008, 2'd2, 1, 1, 32'hCAFE_BABE, 2'd1, 0);  // R5 quad flag ignored on write
        txn(32'h0000_3006, 2'd1, 1, 0, 32'hBEEF_0000, 2'd0, 0);  // R9 half write on 8-bit port
        idle(2);

        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule